// File: doc/BRIEF.md
# Serial ADC Power-Mode Controller

This block is the digital front end of a serial sampling converter. It works in the system clock domain. It watches an active-low chip select and a serial clock, and counts the serial-clock falling edges seen while chip select is low. Each time chip select rises, it uses that count to decide whether the converter keeps running or sleeps. This makes the block immune to short glitches on chip select in both directions: a brief low pulse cannot wake a sleeping device, and a brief high pulse cannot put a running one to sleep.

While a frame is open, a parallel sample value stands in for the analog input. That value is shifted out MSB first, one bit per serial-clock fall. Alongside the data the block gives an output-enable that models the tri-state driver, a mode flag, a flag that marks whether the frame's data is valid, a track/hold indication and the live edge count. The start-up mode is set by a parameter.

Top module: `adcPmTop`

## Requirements
- R1: During and after reset, `pwrDown` equals parameter INIT_PD, `edgeCount` is 0, `sdoEn` is 0, and `trackMode` is the inverse of INIT_PD.
- R2: A falling edge on `csN` clears `edgeCount` to 0. Each `sclk` falling edge while the frame is open adds one to the count, which stops at FRAME_LEN (16). The count holds its value after `csN` rises.
- R3: In run mode (`pwrDown`=0), if `csN` rises with a count from PD_LO (2) to PD_HI-1 (9), the block enters sleep (`pwrDown`=1) and the data output is disabled.
- R4: In run mode, if `csN` rises with a count below 2 or of 10 or more, the block stays in run mode.
- R5: In sleep, if `csN` rises with a count below 10, the block stays asleep. With a count of 10 or more it returns to run mode.
- R6: At each `csN` fall, `dataValid` is set to 1 if the block is in run mode and to 0 if it is asleep. A wake-up frame is therefore invalid, and the frame after it is valid.
- R7: The frame word is FRAME_LEN-RES_BITS zero bits followed by the 12-bit `sample`, sent MSB first. The first bit is on `sdoData` from the `csN` fall onward, and each `sclk` fall moves the next bit onto `sdoData`.
- R8: `sdoEn` is 1 only while the frame is open and the count is below 16. It is 0 while `csN` is high and after the 16th fall, even if `csN` stays low.
- R9: `trackMode` is 1 in run mode. In sleep it is 0 until the first `sclk` edge of either polarity inside a frame, after which it is 1. It goes back to 0 when the block falls asleep again.
- R10: `sclk` edges while `csN` is high change neither `edgeCount` nor `pwrDown`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csN | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sample | input | RES_BITS | Conversion value captured at frame start |
| sdoData | output | 1 | Serial data bit |
| sdoEn | output | 1 | Serial data driver enable |
| pwrDown | output | 1 | 1 = sleep, 0 = run |
| dataValid | output | 1 | Data of the current frame is valid |
| trackMode | output | 1 | 1 = track, 0 = hold |
| edgeCount | output | $clog2(FRAME_LEN+1) | Serial-clock falls counted in the current frame |

## Verification
Each pin change passes two synchroniser flops and one edge-history flop. The registered result therefore appears after the third rising system clock edge that follows the change. The bench holds every `csN` and `sclk` level for six system clocks and samples one nanosecond after a rising edge, so all results have settled when they are read. Mode, enable and track are checked after the `csN` rise. Validity, enable and the first data bit are checked after the `csN` fall. The count and the next data bit are checked after each serial-clock fall.

// File: rtl/adcPmPkg.sv
package adcPmPkg;

  typedef enum logic {
    MODE_RUN   = 1'b0,
    MODE_SLEEP = 1'b1
  } pwrMode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;   // capture a new frame word
    logic shift;  // advance one bit
    logic outEn;  // drive the data pin
  } dpStrobe_t;

endpackage

// File: rtl/adcPmSync.sv
module adcPmSync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic doutPrev
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : gStage
      if (i == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= din;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) doutPrev <= RST_VAL;
    else     doutPrev <= chain[STAGES-1];
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/adcPmCtrl.sv
module adcPmCtrl
  import adcPmPkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int PD_LO     = 2,
  parameter int PD_HI     = 10,
  parameter int SYNC      = 2,
  parameter bit INIT_PD   = 1'b0,
  localparam int CNT_W    = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csN,
  input  logic             sclk,
  output dpStrobe_t        strobe,
  output logic             pwrDown,
  output logic             dataValid,
  output logic             trackMode,
  output logic [CNT_W-1:0] edgeCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_LO  = CNT_W'(PD_LO);
  localparam logic [CNT_W-1:0] CNT_HI  = CNT_W'(PD_HI);

  logic csS, csPrev, sclkS, sclkPrev;
  logic csFall, csRise, sclkFall, sclkEdge;
  logic frameOpen, cntRoom;
  pwrMode_t mode, nextMode;

  adcPmSync #(.STAGES(SYNC), .RST_VAL(1'b1)) uCsSync (
    .clk(clk), .rst(rst), .din(csN), .dout(csS), .doutPrev(csPrev)
  );

  adcPmSync #(.STAGES(SYNC), .RST_VAL(1'b0)) uSclkSync (
    .clk(clk), .rst(rst), .din(sclk), .dout(sclkS), .doutPrev(sclkPrev)
  );

  assign csFall   = csPrev & ~csS;
  assign csRise   = ~csPrev & csS;
  assign sclkFall = sclkPrev & ~sclkS;
  assign sclkEdge = sclkPrev ^ sclkS;
  assign cntRoom  = edgeCount < CNT_MAX;

  // mode decision taken where chip select rises
  always_comb begin
    nextMode = mode;
    unique case (mode)
      MODE_RUN:   if (edgeCount >= CNT_LO && edgeCount < CNT_HI) nextMode = MODE_SLEEP;
      MODE_SLEEP: if (edgeCount >= CNT_HI) nextMode = MODE_RUN;
      default:    nextMode = mode;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= INIT_PD ? MODE_SLEEP : MODE_RUN;
      edgeCount <= '0;
      frameOpen <= 1'b0;
      dataValid <= 1'b0;
    end else if (csFall) begin
      frameOpen <= 1'b1;
      edgeCount <= '0;
      dataValid <= (mode == MODE_RUN);
    end else if (csRise) begin
      frameOpen <= 1'b0;
      mode      <= nextMode;
    end else if (frameOpen && sclkFall && cntRoom) begin
      edgeCount <= edgeCount + 1'b1;
    end
  end

  // track/hold: run mode tracks; sleep holds until a frame sees any sclk edge
  always_ff @(posedge clk) begin
    if (rst)                       trackMode <= ~INIT_PD;
    else if (csRise)               trackMode <= (nextMode == MODE_RUN);
    else if (frameOpen && sclkEdge) trackMode <= 1'b1;
  end

  always_comb begin
    strobe.load  = csFall;
    strobe.shift = frameOpen && sclkFall && cntRoom && !csRise;
    strobe.outEn = frameOpen && cntRoom;
  end

  assign pwrDown = (mode == MODE_SLEEP);

endmodule

// File: rtl/adcPmData.sv
module adcPmData
  import adcPmPkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int RES_BITS  = 12,
  localparam int LEAD     = FRAME_LEN - RES_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  dpStrobe_t           strobe,
  input  logic [RES_BITS-1:0] sample,
  output logic                sdoData,
  output logic                sdoEn
);

  logic [FRAME_LEN-1:0] shReg;

  always_ff @(posedge clk) begin
    if (rst)               shReg <= '0;
    else if (strobe.load)  shReg <= {{LEAD{1'b0}}, sample};
    else if (strobe.shift) shReg <= {shReg[FRAME_LEN-2:0], 1'b0};
  end

  assign sdoEn   = strobe.outEn;
  assign sdoData = strobe.outEn & shReg[FRAME_LEN-1];

endmodule

// File: rtl/adcPmTop.sv
module adcPmTop
  import adcPmPkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int RES_BITS  = 12,
  parameter int PD_LO     = 2,
  parameter int PD_HI     = 10,
  parameter int SYNC      = 2,
  parameter bit INIT_PD   = 1'b0
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               csN,
  input  logic                               sclk,
  input  logic [RES_BITS-1:0]                sample,
  output logic                               sdoData,
  output logic                               sdoEn,
  output logic                               pwrDown,
  output logic                               dataValid,
  output logic                               trackMode,
  output logic [$clog2(FRAME_LEN+1)-1:0]     edgeCount
);

  dpStrobe_t strobe;

  adcPmCtrl #(
    .FRAME_LEN(FRAME_LEN), .PD_LO(PD_LO), .PD_HI(PD_HI),
    .SYNC(SYNC), .INIT_PD(INIT_PD)
  ) uCtrl (
    .clk(clk), .rst(rst), .csN(csN), .sclk(sclk), .strobe(strobe),
    .pwrDown(pwrDown), .dataValid(dataValid), .trackMode(trackMode),
    .edgeCount(edgeCount)
  );

  adcPmData #(.FRAME_LEN(FRAME_LEN), .RES_BITS(RES_BITS)) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .sample(sample),
    .sdoData(sdoData), .sdoEn(sdoEn)
  );

endmodule

// File: rtl/adcPmChk.sv
module adcPmChk #(
  parameter int FRAME_LEN = 16,
  parameter int PD_LO     = 2,
  parameter int PD_HI     = 10,
  localparam int CNT_W    = $clog2(FRAME_LEN + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             sdoEn,
  input logic             pwrDown,
  input logic             dataValid,
  input logic             trackMode,
  input logic [CNT_W-1:0] edgeCount
);

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    int'(edgeCount) <= FRAME_LEN); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (edgeCount != $past(edgeCount) && edgeCount != '0) |->
      int'(edgeCount) == int'($past(edgeCount)) + 1); // R2

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(pwrDown) |-> (int'($past(edgeCount)) >= PD_LO &&
                        int'($past(edgeCount)) < PD_HI)); // R3

  AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(pwrDown) |-> int'($past(edgeCount)) >= PD_HI); // R5

  AST_VALID_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(dataValid) |-> !$past(pwrDown)); // R6

  AST_EN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    sdoEn |-> int'(edgeCount) < FRAME_LEN); // R8

  AST_RUN_TRACK: assert property (@(posedge clk) disable iff (rst)
    !pwrDown |-> trackMode); // R9

endmodule

bind adcPmTop adcPmChk #(.FRAME_LEN(FRAME_LEN), .PD_LO(PD_LO), .PD_HI(PD_HI)) uChk (
  .clk(clk), .rst(rst), .sdoEn(sdoEn), .pwrDown(pwrDown),
  .dataValid(dataValid), .trackMode(trackMode), .edgeCount(edgeCount)
);

// File: tb/sim_adcPmTop.sv
`timescale 1ns/1ps
module sim_adcPmTop;

  localparam int HOLD = 6;
  localparam int NVEC = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic [11:0] sample = '0;
  logic sdoData, sdoEn, pwrDown, dataValid, trackMode;
  logic [4:0] edgeCount;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adcPmTop u0 (
    .clk(clk), .rst(rst), .csN(csN), .sclk(sclk), .sample(sample),
    .sdoData(sdoData), .sdoEn(sdoEn), .pwrDown(pwrDown),
    .dataValid(dataValid), .trackMode(trackMode), .edgeCount(edgeCount)
  );

  // {sample, sclk falls before csN rises, expected sleep after, expected valid}
  localparam logic [18:0] VEC [NVEC] = '{
    {12'hA5C, 5'd16, 1'b0, 1'b1},
    {12'h123, 5'd1,  1'b0, 1'b1},
    {12'hFFF, 5'd2,  1'b1, 1'b1},
    {12'h0F0, 5'd9,  1'b1, 1'b0},
    {12'h3C3, 5'd0,  1'b1, 1'b0},
    {12'h555, 5'd10, 1'b0, 1'b0},
    {12'h9A6, 5'd16, 1'b0, 1'b1},
    {12'h001, 5'd9,  1'b1, 1'b1},
    {12'h800, 5'd16, 1'b0, 1'b0},
    {12'h7E1, 5'd12, 1'b0, 1'b1}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1; wait_clk(HOLD);
    sclk = 1'b0; wait_clk(HOLD);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    // R1 reset state
    chk(pwrDown == 1'b0, "R1 mode", pwrDown, 0);
    chk(edgeCount == 5'd0, "R1 count", edgeCount, 0);
    chk(sdoEn == 1'b0, "R1 enable", sdoEn, 0);
    chk(trackMode == 1'b1, "R1 track", trackMode, 1);
    rst = 1'b0;
    wait_clk(HOLD);

    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] word;
      int nf;
      bit pdBefore, expPd, expValid;
      word = {4'b0, VEC[v][18:7]};
      nf = int'(VEC[v][6:2]);
      expPd = VEC[v][1];
      expValid = VEC[v][0];
      pdBefore = pwrDown;
      sample = VEC[v][18:7];
      csN = 1'b0;
      wait_clk(HOLD);
      chk(dataValid == expValid, "R6 valid", dataValid, expValid);
      chk(sdoEn == 1'b1, "R8 enable open", sdoEn, 1);
      chk(edgeCount == 5'd0, "R2 cleared", edgeCount, 0);
      chk(trackMode == !pdBefore, "R9 track at start", trackMode, !pdBefore);
      chk(sdoData == word[15], "R7 bit0", sdoData, word[15]);
      for (int k = 0; k < nf; k++) begin
        sclk_pulse();
        chk(edgeCount == 5'(k + 1), "R2 count", edgeCount, k + 1);
        if (k == 0) chk(trackMode == 1'b1, "R9 track after edge", trackMode, 1);
        if (k + 1 < 16) begin
          chk(sdoEn == 1'b1, "R8 enable", sdoEn, 1);
          chk(sdoData == word[14 - k], "R7 bit", sdoData, word[14 - k]);
        end else begin
          chk(sdoEn == 1'b0, "R8 enable after 16", sdoEn, 0);
        end
      end
      csN = 1'b1;
      wait_clk(HOLD);
      chk(pwrDown == expPd, expPd ? "R3/R5 mode" : "R4/R5 mode", pwrDown, expPd);
      chk(sdoEn == 1'b0, "R8 enable closed", sdoEn, 0);
      chk(edgeCount == 5'(nf), "R2 hold", edgeCount, nf);
      chk(trackMode == !expPd, "R9 track after frame", trackMode, !expPd);
      wait_clk(HOLD);
    end

    // R10: sclk with csN high is ignored (block is in run mode, count 12)
    for (int k = 0; k < 5; k++) sclk_pulse();
    chk(edgeCount == 5'd12, "R10 count", edgeCount, 12);
    chk(pwrDown == 1'b0, "R10 mode", pwrDown, 0);

    // R2/R8: idle low after a full frame, count saturates
    csN = 1'b0; wait_clk(HOLD);
    for (int k = 0; k < 18; k++) sclk_pulse();
    chk(edgeCount == 5'd16, "R2 saturate", edgeCount, 16);
    chk(sdoEn == 1'b0, "R8 idle low", sdoEn, 0);
    wait_clk(40);
    chk(sdoEn == 1'b0, "R8 idle low hold", sdoEn, 0);
    csN = 1'b1; wait_clk(HOLD);
    chk(pwrDown == 1'b0, "R4 after idle low", pwrDown, 0);

    // R1: reset returns the initial state
    rst = 1'b1; wait_clk(HOLD);
    chk(edgeCount == 5'd0, "R1 count reapplied", edgeCount, 0);
    chk(pwrDown == 1'b0, "R1 mode reapplied", pwrDown, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule